// File: doc/BRIEF.md
# Locality-Aware DRAM Command Picker

This block sits between the per-bank access engines of a DRAM controller and the command bus. Each bank slot (one per bank of every rank) presents the next command its in-flight access needs: a precharge, an activate or a column access, marked as read or write, with an age value and a flag telling whether this command finishes the access. Every cycle the block picks at most one of these commands and issues it on the same cycle.

The pick follows a fixed eight-level ranking. Column accesses to the bank or rank that received the previous command rank highest, so row hits run back to back and the data bus does not turn around between ranks. Precharges and activates come next, since they can overlap data transfers. Column accesses to other ranks rank last. Reads beat writes inside each group, and the older request wins a tie. Each slot has a small down-counter that blocks its next command until the precharge, activate or column delay has passed. The block also remembers which bank and rank it served last, and when nothing can issue it points that memory at the slot holding the oldest request.

Top module: `dram_cmd_picker`

## Requirements
- R1: A slot's command can issue only when its request is valid, its command code is 0 (precharge), 1 (activate) or 2 (column), and its timer has run out. Code 3 never issues. A command issued in cycle n blocks that slot until cycle n+T, where T is T_RP, T_RCD or T_CL for a precharge, an activate or a column access respectively.
- R2: Among column accesses, the ranking is: a read to the last bank ranks 1, a read to another bank of the last rank ranks 2, a write to the last bank ranks 3, and a write to another bank of the last rank ranks 4.
- R3: A read precharge or activate ranks 5 and a write precharge or activate ranks 6, in any bank or rank. A read column access to a rank other than the last rank ranks 7, and a write column access to such a rank ranks 8. The eligible command with the smallest rank issues.
- R4: If two eligible commands share a rank, the one with the larger age value wins. If the ages are also equal, the lower flat index wins, where the flat index is rank*NBANK+bank.
- R5: The issue outputs follow the inputs within the same cycle, and at most one command issues per cycle. On the clock edge after an issue, last_bank and last_rank take the issued bank and rank.
- R6: On a cycle where nothing issues but some request is valid, last_bank and last_rank take the slot with the oldest valid request at the next edge, using the tie order of R4. If no request is valid, they hold.
- R7: resp_valid is high in the same cycle that a column access with req_final set issues, and resp_bank and resp_rank name its slot. Precharges, activates and non-final columns give no response.
- R8: While rst is high nothing issues. Reset sets last_bank and last_rank to 0 and clears all timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NBANK*NRANK | Slot holds a pending command |
| req_cmd | input | 2*NBANK*NRANK | Per-slot command code: 0 precharge, 1 activate, 2 column |
| req_write | input | NBANK*NRANK | Per-slot: command belongs to a write access |
| req_age | input | AGE_W*NBANK*NRANK | Per-slot age value, larger means older |
| req_final | input | NBANK*NRANK | Per-slot: this command finishes its access |
| iss_valid | output | 1 | A command issues this cycle |
| iss_bank | output | BW | Bank of the issued command |
| iss_rank | output | RW | Rank of the issued command |
| iss_cmd | output | 2 | Code of the issued command |
| iss_write | output | 1 | Issued command is for a write |
| resp_valid | output | 1 | An access finished this cycle |
| resp_bank | output | BW | Bank of the finished access |
| resp_rank | output | RW | Rank of the finished access |
| last_bank | output | BW | Bank used as the locality reference |
| last_rank | output | RW | Rank used as the locality reference |

## Verification
The assertions assume that the access engines keep a slot's request fields steady while the request waits, and that ages are set by arrival order. The minimum-gap check also assumes that every timing parameter is above one. The bench drives the inputs only at falling edges and gives distinct ages wherever it expects the age to decide. It resets between table vectors, so the last-bank reference is known to be bank 0 of rank 0. Directed sequences then move that reference, exercise the timer windows and leave cycles with no eligible command.

// File: rtl/dram_cmd_picker.sv
module dram_cmd_picker #(
  parameter int NBANK = 4,
  parameter int NRANK = 2,
  parameter int AGE_W = 8,
  parameter int T_RP  = 5,
  parameter int T_RCD = 5,
  parameter int T_CL  = 5,
  localparam int NB   = NBANK * NRANK,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int RW   = (NRANK > 1) ? $clog2(NRANK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NB-1:0]      req_valid,
  input  logic [2*NB-1:0]    req_cmd,
  input  logic [NB-1:0]      req_write,
  input  logic [AGE_W*NB-1:0] req_age,
  input  logic [NB-1:0]      req_final,
  output logic               iss_valid,
  output logic [BW-1:0]      iss_bank,
  output logic [RW-1:0]      iss_rank,
  output logic [1:0]         iss_cmd,
  output logic               iss_write,
  output logic               resp_valid,
  output logic [BW-1:0]      resp_bank,
  output logic [RW-1:0]      resp_rank,
  output logic [BW-1:0]      last_bank,
  output logic [RW-1:0]      last_rank
);
  localparam int FW   = (NB > 1) ? $clog2(NB) : 1;
  localparam int TMAX = (T_RP > T_RCD) ? ((T_RP > T_CL) ? T_RP : T_CL)
                                       : ((T_RCD > T_CL) ? T_RCD : T_CL);
  localparam int TMIN = (T_RP < T_RCD) ? ((T_RP < T_CL) ? T_RP : T_CL)
                                       : ((T_RCD < T_CL) ? T_RCD : T_CL);
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [1:0] C_PRE = 2'd0;
  localparam logic [1:0] C_ACT = 2'd1;
  localparam logic [1:0] C_COL = 2'd2;

  logic [TW-1:0] tmr [NB];
  logic [NB-1:0] elig;
  logic [3:0]    prio [NB];

  generate
    for (genvar g = 0; g < NB; g++) begin : g_slot
      logic [1:0] cmd;
      logic rd, sr, sb;
      assign cmd = req_cmd[2*g +: 2];
      assign rd  = !req_write[g];
      assign sr  = (last_rank == RW'(g / NBANK));
      assign sb  = sr && (last_bank == BW'(g % NBANK));
      assign elig[g] = req_valid[g] && (tmr[g] == '0) && (cmd != 2'd3);
      assign prio[g] = (cmd != C_COL) ? (rd ? 4'd5 : 4'd6) :
                       sb             ? (rd ? 4'd1 : 4'd3) :
                       sr             ? (rd ? 4'd2 : 4'd4) :
                                        (rd ? 4'd7 : 4'd8);
    end
  endgenerate

  logic             w_found;
  logic [FW-1:0]    w_idx;
  logic [BW-1:0]    w_bank;
  logic [RW-1:0]    w_rank;
  logic [3:0]       w_prio;
  logic [AGE_W-1:0] w_age;
  logic [1:0]       w_cmd;
  logic             w_write, w_final;

  always_comb begin
    w_found = 1'b0; w_idx = '0; w_bank = '0; w_rank = '0;
    w_prio = 4'hf; w_age = '0; w_cmd = '0; w_write = 1'b0; w_final = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (elig[i] && (!w_found || prio[i] < w_prio ||
          (prio[i] == w_prio && req_age[i*AGE_W +: AGE_W] > w_age))) begin
        w_found = 1'b1;
        w_idx   = FW'(i);
        w_bank  = BW'(i % NBANK);
        w_rank  = RW'(i / NBANK);
        w_prio  = prio[i];
        w_age   = req_age[i*AGE_W +: AGE_W];
        w_cmd   = req_cmd[2*i +: 2];
        w_write = req_write[i];
        w_final = req_final[i];
      end
    end
  end

  logic             o_found;
  logic [BW-1:0]    o_bank;
  logic [RW-1:0]    o_rank;
  logic [AGE_W-1:0] o_age;

  always_comb begin
    o_found = 1'b0; o_bank = '0; o_rank = '0; o_age = '0;
    for (int i = 0; i < NB; i++) begin
      if (req_valid[i] && (!o_found || req_age[i*AGE_W +: AGE_W] > o_age)) begin
        o_found = 1'b1;
        o_bank  = BW'(i % NBANK);
        o_rank  = RW'(i / NBANK);
        o_age   = req_age[i*AGE_W +: AGE_W];
      end
    end
  end

  assign iss_valid  = w_found && !rst;
  assign iss_bank   = w_bank;
  assign iss_rank   = w_rank;
  assign iss_cmd    = w_cmd;
  assign iss_write  = w_write;
  assign resp_valid = iss_valid && (w_cmd == C_COL) && w_final;
  assign resp_bank  = w_bank;
  assign resp_rank  = w_rank;

  logic [TW-1:0] t_load;
  always_comb begin
    case (w_cmd)
      C_PRE:   t_load = TW'(T_RP - 1);
      C_ACT:   t_load = TW'(T_RCD - 1);
      default: t_load = TW'(T_CL - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_bank <= '0;
      last_rank <= '0;
      for (int i = 0; i < NB; i++) tmr[i] <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (iss_valid && w_idx == FW'(i)) tmr[i] <= t_load;
        else if (tmr[i] != '0)            tmr[i] <= tmr[i] - 1'b1;
      end
      if (iss_valid) begin
        last_bank <= w_bank;
        last_rank <= w_rank;
      end else if (o_found) begin
        last_bank <= o_bank;
        last_rank <= o_rank;
      end
    end
  end

  logic [FW-1:0] last_flat;
  assign last_flat = FW'(last_rank * NBANK + last_bank);

  assert_last_follows_R5: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> (last_bank == $past(iss_bank) && last_rank == $past(iss_rank)));

  assert_slot_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (TMIN > 1 && iss_valid) |=>
      !(iss_valid && iss_bank == $past(iss_bank) && iss_rank == $past(iss_rank)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!iss_valid && req_valid == '0) |=> ($stable(last_bank) && $stable(last_rank)));

  assert_hit_first_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !(iss_bank == last_bank && iss_rank == last_rank)) |->
      !(req_valid[last_flat] && tmr[last_flat] == '0 &&
        req_cmd[2*last_flat +: 2] == C_COL && !req_write[last_flat]));
endmodule

// File: tb/dram_cmd_picker_test.sv
module dram_cmd_picker_test;
  localparam int NB = 8;
  localparam int T  = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [NB-1:0] req_valid, req_write, req_final;
  logic [15:0]   req_cmd;
  logic [63:0]   req_age;
  logic          iss_valid, iss_write, resp_valid;
  logic [1:0]    iss_bank, resp_bank, last_bank, iss_cmd;
  logic          iss_rank, resp_rank, last_rank;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_cmd_picker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_write(req_write), .req_age(req_age), .req_final(req_final),
    .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_rank(iss_rank),
    .iss_cmd(iss_cmd), .iss_write(iss_write), .resp_valid(resp_valid),
    .resp_bank(resp_bank), .resp_rank(resp_rank),
    .last_bank(last_bank), .last_rank(last_rank));

  // {valid, write, cmd (2b per slot), age (4b per slot), exp_valid, exp_flat}
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {8'b00000011, 8'b00000000, 16'b00_00_00_00_00_00_10_10, 32'h00000091, 1'b1, 3'd0}, // R2 rank1 vs rank2
    {8'b00000011, 8'b00000001, 16'b00_00_00_00_00_00_10_10, 32'h00000011, 1'b1, 3'd1}, // R2 rank2 beats rank3
    {8'b00100100, 8'b00000100, 16'b00_00_01_00_00_10_00_00, 32'h00900100, 1'b1, 3'd2}, // R3 rank4 beats rank5
    {8'b01010000, 8'b01000000, 16'b00_00_00_01_00_00_00_00, 32'h09010000, 1'b1, 3'd4}, // R3 rank5 beats rank6
    {8'b01100000, 8'b01000000, 16'b00_01_10_00_00_00_00_00, 32'h01900000, 1'b1, 3'd6}, // R3 rank6 beats rank7
    {8'b10100000, 8'b10100000, 16'b10_00_10_00_00_00_00_00, 32'h90300000, 1'b1, 3'd7}, // R4 older wins
    {8'b00001010, 8'b00000000, 16'b00_00_00_00_10_00_10_00, 32'h00005050, 1'b1, 3'd1}, // R4 lower index
    {8'b00000000, 8'b00000000, 16'b00_00_00_00_00_00_00_00, 32'h00000000, 1'b0, 3'd0}, // R5 nothing
    {8'b10100000, 8'b10000000, 16'b10_00_10_00_00_00_00_00, 32'h90100000, 1'b1, 3'd5}, // R3 rank7 beats rank8
    {8'b00000001, 8'b00000000, 16'b00_00_00_00_00_00_00_11, 32'h00000001, 1'b0, 3'd0}  // R1 code 3
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = '0; req_write = '0; req_final = '0; req_cmd = '0; req_age = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clear_in();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_slot(input int s, input logic [1:0] c, input logic w,
                          input logic [3:0] a, input logic f);
    req_valid[s] = 1'b1; req_cmd[2*s +: 2] = c; req_write[s] = w;
    req_age[8*s +: 8] = {4'h0, a}; req_final[s] = f;
  endtask

  initial begin
    rst = 1'b1; clear_in();
    // R8: reset state and no issue in reset
    @(negedge clk); @(negedge clk);
    set_slot(3, 2'd1, 1'b0, 4'd1, 1'b0);
    #1;
    chk("R8 no issue in reset", iss_valid, 0);
    chk("R8 last_bank reset", last_bank, 0);
    chk("R8 last_rank reset", last_rank, 0);
    @(negedge clk); rst = 1'b0; clear_in();

    // table walk, reference bank 0 rank 0 after each reset
    for (int v = 0; v < NV; v++) begin
      do_reset();
      req_valid = VEC[v][67:60];
      req_write = VEC[v][59:52];
      req_cmd   = VEC[v][51:36];
      for (int s = 0; s < NB; s++) req_age[8*s +: 8] = {4'h0, VEC[v][4+4*s +: 4]};
      #1;
      chk($sformatf("R2/R3/R4 vec%0d valid", v), iss_valid, VEC[v][3]);
      if (VEC[v][3]) begin
        chk($sformatf("R2/R3/R4 vec%0d bank", v), iss_bank, VEC[v][1:0]);
        chk($sformatf("R2/R3/R4 vec%0d rank", v), iss_rank, VEC[v][2]);
      end
    end

    // R5: last follows issue; R2 locality shift
    do_reset();
    set_slot(6, 2'd1, 1'b0, 4'd1, 1'b0);
    #1 chk("R5 issue same cycle", iss_valid, 1);
    @(negedge clk); clear_in();
    chk("R5 last_bank", last_bank, 2);
    chk("R5 last_rank", last_rank, 1);
    set_slot(7, 2'd2, 1'b0, 4'd1, 1'b0);
    set_slot(0, 2'd2, 1'b0, 4'd9, 1'b0);
    #1 chk("R2 same rank beats other rank bank", iss_bank, 3);
    chk("R2 same rank beats other rank rank", iss_rank, 1);
    // R6: both blocked, oldest becomes reference
    @(negedge clk); clear_in();
    set_slot(6, 2'd1, 1'b0, 4'd9, 1'b0);
    set_slot(7, 2'd1, 1'b0, 4'd2, 1'b0);
    #1 chk("R1 blocked slots do not issue", iss_valid, 0);
    @(negedge clk); clear_in();
    chk("R6 oldest bank", last_bank, 2);
    chk("R6 oldest rank", last_rank, 1);

    // R1: timer window for an activate
    do_reset();
    set_slot(3, 2'd1, 1'b0, 4'd1, 1'b0);
    #1 chk("R1 first issue", iss_valid, 1);
    for (int k = 1; k < T; k++) begin
      @(negedge clk); #1;
      chk($sformatf("R1 blocked at +%0d", k), iss_valid, 0);
    end
    @(negedge clk); #1;
    chk("R1 reissue at +T", iss_valid, 1);
    // R6 hold with no requests
    @(negedge clk); clear_in();
    @(negedge clk); @(negedge clk);
    chk("R6 hold bank", last_bank, 3);
    chk("R6 hold rank", last_rank, 0);

    // R7: responses
    do_reset();
    set_slot(2, 2'd2, 1'b0, 4'd1, 1'b1);
    #1 chk("R7 final column response", resp_valid, 1);
    chk("R7 response bank", resp_bank, 2);
    chk("R7 response rank", resp_rank, 0);
    @(negedge clk); clear_in();
    set_slot(1, 2'd2, 1'b0, 4'd1, 1'b0);
    #1 chk("R7 non-final column issues", iss_valid, 1);
    chk("R7 non-final no response", resp_valid, 0);
    @(negedge clk); clear_in();
    set_slot(5, 2'd1, 1'b0, 4'd1, 1'b1);
    #1 chk("R7 activate issues", iss_cmd, 1);
    chk("R7 activate no response", resp_valid, 0);
    @(negedge clk); clear_in();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule